// File: doc/BRIEF.md
# I2C Clock-Stretch and Bus-Acquire Timeout Monitor

This block sits beside an I2C master controller and runs two independent watchdogs. The first measures how long the serial clock line stays low. A slave that stretches the clock past a programmed number of microsecond ticks raises a sticky status flag and a one-cycle interrupt pulse. The second measures how long the master takes to get from the start of an operation to an acknowledge or not-acknowledge on the address byte. It counts millisecond ticks, and when it expires it raises a sticky status flag and a one-cycle abort request to the master.

The clock-line input is asynchronous, so it passes through a synchronizer before edge detection. The tick strobes come from dividers outside the block, and each strobe is one clock cycle wide. Either limit can be set to zero, which turns that watchdog off. While a boot-load sequence is active, the bus-acquire watchdog is frozen. Typical programming is 0x65BB for the clock-low limit (about 26 ms with 1 µs ticks) and 0x0033 for the bus-acquire limit (51 ms).

Top module: `i2c_stall_watch`

## Requirements
- R1: After reset, `lowTimeoutFlag`, `arbTimeoutFlag`, `lowTimeoutIrq` and `abortReq` are all 0.
- R2: A falling edge of `sclIn` opens the clock-low window with a count of zero. The edge takes effect two clock edges after the input changes, and the window is open from the third edge. The window counts `usTick` pulses. On the clock edge that samples the `lowLimit`-th tick, `lowTimeoutFlag` is set, and it is visible after that edge. No earlier tick sets it.
- R3: When `lowLimit` is 0, the clock-low watchdog never sets its flag or pulses its interrupt, whatever the number of ticks.
- R4: A rising edge of `sclIn` closes the clock-low window. If the rise reaches the edge logic in the same cycle as the terminal tick, the rise wins and no timeout is reported. The next falling edge restarts the count from zero.
- R5: `lowTimeoutIrq` is high for exactly one cycle per expiry, in the same cycle the flag first shows set. Ticks after the expiry within the same low period produce no further pulse.
- R6: A `mstStart` pulse opens the bus-acquire window with a count of zero. `arbTimeoutFlag` is set on the edge that samples the `arbLimit`-th `msTick` after the start, and not before.
- R7: When `arbLimit` is 0, the bus-acquire watchdog never sets its flag and never requests an abort.
- R8: A `msTick` sampled while `bootActive` is 1 does not advance the bus-acquire count and cannot cause an expiry.
- R9: `addrAckRcvd` closes the bus-acquire window. If it arrives on the same edge as the terminal tick, no timeout is reported, and later ticks have no effect until the next start.
- R10: `abortReq` is high for exactly one cycle per bus-acquire expiry, together with the flag first showing set.
- R11: Each flag stays set until its clear strobe (`clrLowFlag` or `clrArbFlag`) is sampled at 1. If an expiry and a clear meet on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-cycle microsecond strobe |
| msTick | input | 1 | One-cycle millisecond strobe |
| sclIn | input | 1 | Raw I2C clock line level |
| mstStart | input | 1 | Pulse: master operation started |
| addrAckRcvd | input | 1 | Pulse: ACK or NACK seen for address byte |
| bootActive | input | 1 | Boot-load sequence in progress |
| lowLimit | input | CNT_W | Clock-low limit in microsecond ticks, 0 = off |
| arbLimit | input | CNT_W | Bus-acquire limit in millisecond ticks, 0 = off |
| clrLowFlag | input | 1 | Write-one-to-clear strobe for clock-low flag |
| clrArbFlag | input | 1 | Write-one-to-clear strobe for bus-acquire flag |
| lowTimeoutFlag | output | 1 | Sticky clock-low timeout status |
| arbTimeoutFlag | output | 1 | Sticky bus-acquire timeout status |
| lowTimeoutIrq | output | 1 | One-cycle clock-low timeout pulse |
| abortReq | output | 1 | One-cycle abort request to the master |

## Verification
The properties take for granted that `mstStart` and `addrAckRcvd` are single-cycle pulses that never coincide. They also assume the limits only change while the matching window is idle, so a sampled limit of zero means the watchdog is off for that expiry decision. The stimulus drives every input on the falling clock edge. It changes a limit only after closing the window and clearing the flag, and it holds `sclIn` steady long enough for the synchronizer and edge logic to settle before any tick it aligns against an edge.

// File: rtl/stall_watch_pkg.sv
package stall_watch_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_LOW = 0;
  localparam int CH_ARB = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] restart;
    logic [NUM_CH-1:0] advance;
  } cntStrobes_t;
endpackage

// File: rtl/stall_watch_dp.sv
module stall_watch_dp
  import stall_watch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobes_t       strb,
  input  logic [CNT_W-1:0]  lowLimit,
  input  logic [CNT_W-1:0]  arbLimit,
  output logic [NUM_CH-1:0] lastStep
);
  logic [CNT_W-1:0] limitArr [NUM_CH];
  logic [CNT_W-1:0] countArr [NUM_CH];

  assign limitArr[CH_LOW] = lowLimit;
  assign limitArr[CH_ARB] = arbLimit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   countArr[ch] <= '0;
      else if (strb.restart[ch])   countArr[ch] <= '0;
      else if (strb.advance[ch])   countArr[ch] <= countArr[ch] + 1'b1;
    end

    // next accepted tick reaches the programmed limit
    assign lastStep[ch] = (limitArr[ch] != '0) &&
                          (countArr[ch] == limitArr[ch] - 1'b1);
  end
endmodule

// File: rtl/stall_watch_ctrl.sv
module stall_watch_ctrl
  import stall_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              msTick,
  input  logic              sclIn,
  input  logic              mstStart,
  input  logic              addrAckRcvd,
  input  logic              bootActive,
  input  logic              clrLowFlag,
  input  logic              clrArbFlag,
  input  logic [NUM_CH-1:0] lastStep,
  output cntStrobes_t       strb,
  output logic              lowTimeoutFlag,
  output logic              arbTimeoutFlag,
  output logic              lowTimeoutIrq,
  output logic              abortReq
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic sclNow, sclPrev, fallEdge, riseEdge;
  logic lowOpen, arbOpen, lowAdv, arbAdv, lowHit, arbHit;

  // line synchronizer, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sclPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sclPrev <= sclNow;
    end
  end

  assign sclNow   = sclPipe[SYNC_STAGES-1];
  assign fallEdge = sclPrev & ~sclNow;
  assign riseEdge = ~sclPrev & sclNow;

  // window tracking
  assign lowAdv = lowOpen & usTick;
  assign lowHit = lowAdv & lastStep[CH_LOW] & ~riseEdge;
  assign arbAdv = arbOpen & msTick & ~bootActive;
  assign arbHit = arbAdv & lastStep[CH_ARB] & ~addrAckRcvd & ~mstStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowOpen <= 1'b0;
      arbOpen <= 1'b0;
    end else begin
      if (fallEdge)               lowOpen <= 1'b1;
      else if (riseEdge || lowHit) lowOpen <= 1'b0;

      if (addrAckRcvd || arbHit)  arbOpen <= 1'b0;
      else if (mstStart)          arbOpen <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.restart[CH_LOW] = fallEdge;
    strb.restart[CH_ARB] = mstStart;
    strb.advance[CH_LOW] = lowAdv;
    strb.advance[CH_ARB] = arbAdv;
  end

  // status and event outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowTimeoutFlag <= 1'b0;
      arbTimeoutFlag <= 1'b0;
      lowTimeoutIrq  <= 1'b0;
      abortReq       <= 1'b0;
    end else begin
      lowTimeoutIrq <= lowHit;
      abortReq      <= arbHit;
      if (lowHit)          lowTimeoutFlag <= 1'b1;
      else if (clrLowFlag) lowTimeoutFlag <= 1'b0;
      if (arbHit)          arbTimeoutFlag <= 1'b1;
      else if (clrArbFlag) arbTimeoutFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_stall_watch.sv
module i2c_stall_watch
  import stall_watch_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             msTick,
  input  logic             sclIn,
  input  logic             mstStart,
  input  logic             addrAckRcvd,
  input  logic             bootActive,
  input  logic [CNT_W-1:0] lowLimit,
  input  logic [CNT_W-1:0] arbLimit,
  input  logic             clrLowFlag,
  input  logic             clrArbFlag,
  output logic             lowTimeoutFlag,
  output logic             arbTimeoutFlag,
  output logic             lowTimeoutIrq,
  output logic             abortReq
);
  cntStrobes_t       strb;
  logic [NUM_CH-1:0] lastStep;

  stall_watch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .msTick(msTick),
    .sclIn(sclIn), .mstStart(mstStart), .addrAckRcvd(addrAckRcvd),
    .bootActive(bootActive), .clrLowFlag(clrLowFlag),
    .clrArbFlag(clrArbFlag), .lastStep(lastStep), .strb(strb),
    .lowTimeoutFlag(lowTimeoutFlag), .arbTimeoutFlag(arbTimeoutFlag),
    .lowTimeoutIrq(lowTimeoutIrq), .abortReq(abortReq)
  );

  stall_watch_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lowLimit(lowLimit), .arbLimit(arbLimit), .lastStep(lastStep)
  );
endmodule

// File: rtl/stall_watch_chk.sv
module stall_watch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             bootActive,
  input logic             addrAckRcvd,
  input logic [CNT_W-1:0] lowLimit,
  input logic [CNT_W-1:0] arbLimit,
  input logic             clrLowFlag,
  input logic             clrArbFlag,
  input logic             lowTimeoutFlag,
  input logic             arbTimeoutFlag,
  input logic             lowTimeoutIrq,
  input logic             abortReq
);
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    lowTimeoutIrq |=> !lowTimeoutIrq);
  a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    lowTimeoutIrq |-> lowTimeoutFlag);
  a_r10_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);
  a_r10_abort_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> arbTimeoutFlag);
  a_r3_low_off: assert property (@(posedge clk) disable iff (!rstN)
    (lowLimit == '0) |=> !lowTimeoutIrq);
  a_r7_arb_off: assert property (@(posedge clk) disable iff (!rstN)
    (arbLimit == '0) |=> !abortReq);
  a_r8_boot_hold: assert property (@(posedge clk) disable iff (!rstN)
    bootActive |=> !abortReq);
  a_r9_ack_wins: assert property (@(posedge clk) disable iff (!rstN)
    addrAckRcvd |=> !abortReq);
  a_r11_low_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lowTimeoutFlag && !clrLowFlag) |=> lowTimeoutFlag);
  a_r11_arb_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (arbTimeoutFlag && !clrArbFlag) |=> arbTimeoutFlag);
  a_r11_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrLowFlag |=> (!lowTimeoutFlag || lowTimeoutIrq));
  a_r11_arb_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrArbFlag |=> (!arbTimeoutFlag || abortReq));
endmodule

bind i2c_stall_watch stall_watch_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_i2c_stall_watch.sv
`timescale 1ns/1ps
module tb_i2c_stall_watch;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 0, msTick = 0, sclIn = 1, mstStart = 0, addrAckRcvd = 0;
  logic bootActive = 0, clrLowFlag = 0, clrArbFlag = 0;
  logic [W-1:0] lowLimit = '0, arbLimit = '0;
  logic lowTimeoutFlag, arbTimeoutFlag, lowTimeoutIrq, abortReq;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  i2c_stall_watch #(.CNT_W(W)) dut (.*);

  task automatic chk(string req, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sclFall();
    sclIn = 1'b0;
    repeat (3) step();
  endtask

  task automatic sclRise();
    sclIn = 1'b1;
    repeat (3) step();
  endtask

  task automatic usPulse();
    usTick = 1'b1; step(); usTick = 1'b0;
  endtask

  task automatic msPulse();
    msTick = 1'b1; step(); msTick = 1'b0;
  endtask

  task automatic clearAll();
    clrLowFlag = 1'b1; clrArbFlag = 1'b1; step();
    clrLowFlag = 1'b0; clrArbFlag = 1'b0; step();
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R1 low flag", lowTimeoutFlag, 1'b0);
    chk("R1 arb flag", arbTimeoutFlag, 1'b0);
    chk("R1 irq", lowTimeoutIrq, 1'b0);
    chk("R1 abort", abortReq, 1'b0);

    // R2 R3 R5: sweep clock-low limit against tick count
    for (int lim = 0; lim <= 5; lim++) begin
      lowLimit = W'(lim);
      sclFall();
      for (int k = 1; k <= 7; k++) begin
        usPulse();
        chk(lim == 0 ? "R3 low off flag" : "R2 low flag",
            lowTimeoutFlag, (lim != 0) && (k >= lim));
        chk("R5 irq pulse", lowTimeoutIrq, (lim != 0) && (k == lim));
        step();
        chk("R5 irq gone", lowTimeoutIrq, 1'b0);
      end
      sclRise();
      usPulse();
      chk("R11 sticky while high", lowTimeoutFlag, lim != 0);
      clearAll();
      chk("R11 low cleared", lowTimeoutFlag, 1'b0);
    end

    // R4: rise on the terminal tick wins, then restart from zero
    lowLimit = W'(3);
    sclFall();
    usPulse(); usPulse();
    sclIn = 1'b1; step(); step();
    usPulse();
    chk("R4 rise wins", lowTimeoutFlag, 1'b0);
    chk("R4 rise wins irq", lowTimeoutIrq, 1'b0);
    step();
    sclFall();
    usPulse(); usPulse();
    chk("R4 restart from zero", lowTimeoutFlag, 1'b0);
    usPulse();
    chk("R4 restart expires", lowTimeoutFlag, 1'b1);
    sclRise();
    clearAll();

    // R11: expiry and clear on the same edge keep the flag set
    lowLimit = W'(1);
    sclFall();
    usTick = 1'b1; clrLowFlag = 1'b1; step();
    usTick = 1'b0; clrLowFlag = 1'b0;
    chk("R11 set beats clear", lowTimeoutFlag, 1'b1);
    sclRise();
    clearAll();

    // R6 R7 R10: sweep bus-acquire limit
    for (int lim = 0; lim <= 4; lim++) begin
      arbLimit = W'(lim);
      mstStart = 1'b1; step(); mstStart = 1'b0;
      for (int k = 1; k <= lim + 2; k++) begin
        msPulse();
        chk(lim == 0 ? "R7 arb off flag" : "R6 arb flag",
            arbTimeoutFlag, (lim != 0) && (k >= lim));
        chk("R10 abort pulse", abortReq, (lim != 0) && (k == lim));
      end
      addrAckRcvd = 1'b1; step(); addrAckRcvd = 1'b0;
      clearAll();
      chk("R11 arb cleared", arbTimeoutFlag, 1'b0);
    end

    // R8: boot load freezes the bus-acquire count
    arbLimit = W'(2);
    mstStart = 1'b1; step(); mstStart = 1'b0;
    bootActive = 1'b1;
    repeat (5) msPulse();
    chk("R8 boot frozen", arbTimeoutFlag, 1'b0);
    bootActive = 1'b0;
    msPulse();
    chk("R8 one counted", arbTimeoutFlag, 1'b0);
    msPulse();
    chk("R8 expires after boot", arbTimeoutFlag, 1'b1);
    chk("R10 abort after boot", abortReq, 1'b1);
    clearAll();

    // R9: acknowledge on the terminal tick wins and closes window
    mstStart = 1'b1; step(); mstStart = 1'b0;
    msPulse();
    msTick = 1'b1; addrAckRcvd = 1'b1; step();
    msTick = 1'b0; addrAckRcvd = 1'b0;
    chk("R9 ack wins", arbTimeoutFlag, 1'b0);
    chk("R9 no abort", abortReq, 1'b0);
    repeat (4) msPulse();
    chk("R9 closed window", arbTimeoutFlag, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule